// File: doc/BRIEF.md
# Configurable 32-Source Interrupt Aggregator

This block gathers 32 interrupt lines into one request line for a processor. Each input is first brought into the local clock domain through a two-stage synchroniser. Software then selects, per input, one of four trigger kinds: rising edge, falling edge, high level or low level. Edge events are latched in a pending flag that software clears by writing a one. Level inputs show their present qualified state instead of a latched flag. A per-source enable mask decides which sources may drive the combined request.

The combined request is the OR over all sources of status AND enable. The output pin presents it either as a level or as a one-cycle pulse on each new request, and either active high or active low. Software may also raise a pending flag directly through a force register, which reads back as zero.

Access is through a plain 32-bit register port. It has a byte address, a write strobe with write data, and a read strobe. Read data appears registered one cycle after the read strobe.

Top module: `irq_aggregator`

## Requirements
- R1: Registers sit at byte offsets: 0x00 enable mask, 0x04 status, 0x08 source mode, 0x0C source polarity, 0x10 output mode (bit 0), 0x14 output polarity (bit 0), 0x18 force. Bit i of each source register belongs to source i. A read strobe in one cycle presents that register on rd_data_o after the next clock edge.
- R2: After reset, enable, source mode, source polarity, output mode, output polarity and every pending flag are zero. With no request, irq_o is high.
- R3: A source's (mode, polarity) bit pair selects its trigger: (1,1) rising edge, (1,0) falling edge, (0,1) high level, (0,0) low level. An edge source sets its pending flag on the selected edge of its input, and only on that edge. Through the two-flop synchroniser, an input change set up before clock edge k is latched at edge k+2.
- R4: A level source's status bit reads the live synchronised level, qualified by polarity. It holds no latched state, so writing one to its status bit changes nothing.
- R5: Writing 1 to a status bit clears that source's pending flag. Writing 0 leaves it unchanged. Writing all ones clears every flag.
- R6: When an edge is detected in the same cycle as a write-one clear of the same bit, the pending flag stays set.
- R7: Writing 1 to a force bit sets that edge source's pending flag. The force register always reads back as zero.
- R8: The request is the OR over all sources of status AND enable. A source whose enable bit is 0 cannot drive irq_o.
- R9: With output mode 0, irq_o is the request level. It is inverted when output polarity is 0, so an idle line is high, and non-inverted when output polarity is 1.
- R10: With output mode 1, irq_o gives a one-cycle pulse when the request rises. The pulse is high when output polarity is 1. It is low, on an idle-high line, when output polarity is 0.
- R11: Reads at any other address, including addresses not aligned to a word, return zero. Writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Asynchronous interrupt source inputs |
| addr_i | input | 5 | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt output |

## Verification
The risky collision is a freshly detected input edge landing on the same clock edge as a software write-one clear of that bit. The bench sets up a rising input and counts the synchroniser stages, so that the clear write is sampled on the same clock edge that latches the edge. It then reads status and expects the bit still set. A second clear, with no new edge, must then empty the bit, which shows the first clear was not simply ignored.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned OFF_EN    = 'h00;
  localparam int unsigned OFF_STAT  = 'h04;
  localparam int unsigned OFF_SMODE = 'h08;
  localparam int unsigned OFF_SPOL  = 'h0C;
  localparam int unsigned OFF_OMODE = 'h10;
  localparam int unsigned OFF_OPOL  = 'h14;
  localparam int unsigned OFF_FORCE = 'h18;

  // {mode, polarity}
  typedef enum logic [1:0] {
    TRIG_LVL_LO = 2'b00,
    TRIG_LVL_HI = 2'b01,
    TRIG_FALL   = 2'b10,
    TRIG_RISE   = 2'b11
  } trig_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqc_src.sv
module irqc_src
  import irqc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic mode_i,
  input  logic pol_i,
  input  logic clr_i,
  input  logic force_i,
  output logic status_o
);
  logic  prev_q, pend_q, pend_d;
  logic  hit, level;
  trig_e trig;

  assign trig  = trig_e'({mode_i, pol_i});
  assign level = pol_i ? sync_i : ~sync_i;

  always_comb begin
    unique case (trig)
      TRIG_RISE: hit = sync_i & ~prev_q;
      TRIG_FALL: hit = ~sync_i & prev_q;
      default:   hit = 1'b0;
    endcase
  end

  // a new edge wins over a same-cycle clear
  always_comb begin
    if (!mode_i) pend_d = 1'b0;
    else         pend_d = (pend_q & ~clr_i) | hit | force_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= sync_i;
      pend_q <= pend_d;
    end
  end

  assign status_o = mode_i ? pend_q : level;

  AST_EDGE_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && hit) |=> pend_q); // R3

  AST_CLASH_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && hit && clr_i) |=> pend_q); // R6

  AST_FORCE_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && force_i) |=> pend_q); // R7

  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && clr_i && !hit && !force_i) |=> !pend_q); // R5

  AST_LEVEL_NO_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |=> !pend_q); // R4
endmodule

// File: rtl/irqc_out.sv
module irqc_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic mode_i,
  input  logic pol_i,
  output logic irq_o
);
  logic req_q, pulse, act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= req_i;
  end

  assign pulse = req_i & ~req_q;
  assign act   = mode_i ? pulse : req_i;
  assign irq_o = pol_i ? act : ~act;

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && irq_o == pol_i) |=> (!mode_i || !$stable(pol_i) || irq_o != pol_i)); // R10

  AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i && !pol_i) |-> irq_o); // R9
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqc_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [N_SRC-1:0]  wr_data_i,
  input  logic              rd_en_i,
  output logic [N_SRC-1:0]  rd_data_o,
  output logic              irq_o
);
  localparam int SYNC_STAGES = 2;

  logic [N_SRC-1:0] en_q, smode_q, spol_q, rd_q, rd_mux;
  logic [N_SRC-1:0] sync, stat, clr, frc;
  logic             omode_q, opol_q, req;
  logic sel_en, sel_stat, sel_smode, sel_spol, sel_omode, sel_opol, sel_force, hit;

  assign sel_en    = addr_i == ADDR_W'(OFF_EN);
  assign sel_stat  = addr_i == ADDR_W'(OFF_STAT);
  assign sel_smode = addr_i == ADDR_W'(OFF_SMODE);
  assign sel_spol  = addr_i == ADDR_W'(OFF_SPOL);
  assign sel_omode = addr_i == ADDR_W'(OFF_OMODE);
  assign sel_opol  = addr_i == ADDR_W'(OFF_OPOL);
  assign sel_force = addr_i == ADDR_W'(OFF_FORCE);
  assign hit = sel_en | sel_stat | sel_smode | sel_spol | sel_omode | sel_opol | sel_force;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      smode_q <= '0;
      spol_q  <= '0;
      omode_q <= 1'b0;
      opol_q  <= 1'b0;
    end else if (wr_en_i) begin
      if (sel_en)    en_q    <= wr_data_i;
      if (sel_smode) smode_q <= wr_data_i;
      if (sel_spol)  spol_q  <= wr_data_i;
      if (sel_omode) omode_q <= wr_data_i[0];
      if (sel_opol)  opol_q  <= wr_data_i[0];
    end
  end

  assign clr = (wr_en_i && sel_stat)  ? wr_data_i : '0;
  assign frc = (wr_en_i && sel_force) ? wr_data_i : '0;

  irqc_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (sync)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    irqc_src u_src (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sync_i  (sync[i]),
      .mode_i  (smode_q[i]),
      .pol_i   (spol_q[i]),
      .clr_i   (clr[i]),
      .force_i (frc[i]),
      .status_o(stat[i])
    );
  end

  assign req = |(stat & en_q);

  irqc_out u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req),
    .mode_i(omode_q),
    .pol_i (opol_q),
    .irq_o (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    if (sel_en)    rd_mux = en_q;
    if (sel_stat)  rd_mux = stat;
    if (sel_smode) rd_mux = smode_q;
    if (sel_spol)  rd_mux = spol_q;
    if (sel_omode) rd_mux = N_SRC'(omode_q);
    if (sel_opol)  rd_mux = N_SRC'(opol_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_mux;
  end

  assign rd_data_o = rd_q;

  AST_UNMAPPED_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !hit) |=> rd_data_o == '0); // R11

  AST_FORCE_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && sel_force) |=> rd_data_o == '0); // R7

  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !req); // R8
endmodule

// File: tb/test_irq_aggregator.sv
`timescale 1ns/1ps
module test_irq_aggregator;
  localparam int N = 32;
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_IRQ = 2'd2;

  typedef struct packed {
    logic [1:0]  kind;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [31:0] src;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VECS [NV] = '{
    {K_WR,  5'h08, 32'h0000_000F, 32'h0, 8'd3},  // R3 sources 0..3 edge
    {K_WR,  5'h0C, 32'hFFFF_FFF5, 32'h0, 8'd3},  // R3 0,2 rise; 1,3 fall; rest level high
    {K_WR,  5'h04, 32'hFFFF_FFFF, 32'h0, 8'd5},
    {K_RD,  5'h04, 32'h0000_0000, 32'h0, 8'd5},  // R5
    {K_RD,  5'h04, 32'h0000_0001, 32'h1, 8'd3},  // R3 rising latched
    {K_RD,  5'h04, 32'h0000_0001, 32'h0, 8'd3},  // R3 held after fall
    {K_RD,  5'h04, 32'h0000_0001, 32'hA, 8'd3},  // R3 rise ignored on falling sources
    {K_RD,  5'h04, 32'h0000_000B, 32'h0, 8'd3},  // R3 falling latched
    {K_WR,  5'h04, 32'h0000_0002, 32'h0, 8'd5},
    {K_RD,  5'h04, 32'h0000_0009, 32'h0, 8'd5},  // R5 single clear
    {K_WR,  5'h04, 32'h0000_0000, 32'h0, 8'd5},
    {K_RD,  5'h04, 32'h0000_0009, 32'h0, 8'd5},  // R5 zero write no effect
    {K_RD,  5'h04, 32'h0000_0039, 32'h30, 8'd4}, // R4 live level high
    {K_WR,  5'h04, 32'h0000_0030, 32'h30, 8'd4},
    {K_RD,  5'h04, 32'h0000_0039, 32'h30, 8'd4}, // R4 clear of level ignored
    {K_RD,  5'h04, 32'h0000_0009, 32'h0, 8'd4},  // R4 level follows input
    {K_IRQ, 5'h00, 32'h0000_0001, 32'h0, 8'd8},  // R8 all masked
    {K_WR,  5'h00, 32'h0000_0004, 32'h0, 8'd8},
    {K_IRQ, 5'h00, 32'h0000_0001, 32'h0, 8'd8},  // R8 enabled source idle
    {K_WR,  5'h00, 32'h0000_0008, 32'h0, 8'd9},
    {K_IRQ, 5'h00, 32'h0000_0000, 32'h0, 8'd9},  // R9 active low
    {K_WR,  5'h14, 32'h0000_0001, 32'h0, 8'd9},
    {K_IRQ, 5'h00, 32'h0000_0001, 32'h0, 8'd9},  // R9 active high
    {K_RD,  5'h00, 32'h0000_0008, 32'h0, 8'd1},  // R1
    {K_RD,  5'h14, 32'h0000_0001, 32'h0, 8'd1},  // R1
    {K_RD,  5'h08, 32'h0000_000F, 32'h0, 8'd1},  // R1
    {K_RD,  5'h0C, 32'hFFFF_FFF5, 32'h0, 8'd1},  // R1
    {K_WR,  5'h04, 32'hFFFF_FFFF, 32'h0, 8'd5},
    {K_RD,  5'h04, 32'h0000_0000, 32'h0, 8'd5},  // R5 all-ones clear
    {K_IRQ, 5'h00, 32'h0000_0000, 32'h0, 8'd9},  // R9 no request
    {K_WR,  5'h18, 32'h0000_0004, 32'h0, 8'd7},
    {K_RD,  5'h04, 32'h0000_0004, 32'h0, 8'd7},  // R7 force sets
    {K_RD,  5'h18, 32'h0000_0000, 32'h0, 8'd7},  // R7 reads zero
    {K_WR,  5'h1C, 32'hFFFF_FFFF, 32'h0, 8'd11},
    {K_WR,  5'h01, 32'hFFFF_FFFF, 32'h0, 8'd11},
    {K_RD,  5'h1C, 32'h0000_0000, 32'h0, 8'd11}, // R11
    {K_RD,  5'h00, 32'h0000_0008, 32'h0, 8'd11}  // R11 writes ignored
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src = '0;
  logic [4:0]    addr = '0;
  logic          we = 1'b0, re = 1'b0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata;
  logic          irq;
  int            total = 0, bad = 0;

  always #10 clk = ~clk;

  irq_aggregator i_irq_aggregator (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .src_i    (src),
    .addr_i   (addr),
    .wr_en_i  (we),
    .wr_data_i(wdata),
    .rd_en_i  (re),
    .rd_data_o(rdata),
    .irq_o    (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R2 irq idle", {31'b0, irq}, 32'h1);
    bus_rd(5'h00, r); chk("R2 enable", r, 32'h0);
    bus_rd(5'h08, r); chk("R2 mode", r, 32'h0);
    bus_rd(5'h10, r); chk("R2 out mode", r, 32'h0);

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
      src = VECS[v].src;
      settle();
      case (VECS[v].kind)
        K_WR:  bus_wr(VECS[v].addr, VECS[v].data);
        K_RD:  begin bus_rd(VECS[v].addr, r); chk(tag, r, VECS[v].data); end
        default: chk(tag, {31'b0, irq}, VECS[v].data);
      endcase
    end

    // R6: edge and clear on the same edge
    src = '0; settle();
    bus_wr(5'h04, 32'hFFFF_FFFF);
    @(negedge clk); src[2] = 1'b1;
    @(negedge clk);
    @(negedge clk); we = 1'b1; addr = 5'h04; wdata = 32'h4;
    @(negedge clk); we = 1'b0;
    bus_rd(5'h04, r); chk("R6 clash keeps", r, 32'h4);
    bus_wr(5'h04, 32'h4);
    bus_rd(5'h04, r); chk("R5 later clear", r, 32'h0);

    // R3: two-stage latency seen at irq_o (level, active high)
    bus_wr(5'h00, 32'h1);
    settle();
    @(negedge clk); src[0] = 1'b1;
    @(negedge clk); chk("R3 k", {31'b0, irq}, 32'h0);
    @(negedge clk); chk("R3 k+1", {31'b0, irq}, 32'h0);
    @(negedge clk); chk("R3 k+2", {31'b0, irq}, 32'h1);

    // R10: edge output, high pulse
    bus_wr(5'h04, 32'h1);
    bus_wr(5'h10, 32'h1);
    src[0] = 1'b0; settle();
    chk("R10 idle high-pol", {31'b0, irq}, 32'h0);
    src[0] = 1'b1;
    cnt = 0;
    for (int c = 0; c < 8; c++) begin @(negedge clk); if (irq) cnt++; end
    chk("R10 high pulse width", cnt, 1);

    // R10: edge output, low pulse
    bus_wr(5'h14, 32'h0);
    bus_wr(5'h04, 32'h1);
    src[0] = 1'b0; settle();
    chk("R10 idle low-pol", {31'b0, irq}, 32'h1);
    src[0] = 1'b1;
    cnt = 0;
    for (int c = 0; c < 8; c++) begin @(negedge clk); if (!irq) cnt++; end
    chk("R10 low pulse width", cnt, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule